// File: doc/BRIEF.md
# Dual-Channel Serial Port Host Register Decoder

This block sits between a host processor bus and two serial port channels. It decodes a chip select and an address into one of two per-channel register banks, stores the control registers each channel keeps, and returns read data. Each bank holds a line control byte, an interrupt enable byte, a modem control byte, a scratch byte, a FIFO enable bit and a 16-bit divisor split into low and high bytes. The status registers return fixed stub values, because the shift engines, FIFOs and baud logic live elsewhere.

The block has two host bus styles, and a strap input picks one while reset is held. In the split-strobe style, each channel has its own active-low select, and there are separate active-low read and write strobes. Pulling both selects low writes one value into the same register of both channels in a single cycle. A read with both channels selected returns nothing. In the single-strobe style, one active-low select enables the device. Address bit 3 picks the channel, and a single read/not-write line gives the direction.

While both divisor bytes of a channel are zero, the divisor locations return an identification code instead of the stored value. The high byte returns the device code and the low byte returns the revision code. Software can therefore identify the part right after reset.

Top module: `duart_host_decoder`

## Requirements
- R1: While `rst_n` is low, every register of both channels returns to its default: line control 0x00, interrupt enable 0x00, modem control 0x00, scratch 0xFF, divisor low and high 0x00, and FIFO enable 0.
- R2: In split-strobe mode (`intel_mode`=1 at reset), `cs0_n`/`cs1_n` = 1/1 selects no channel, 0/1 selects channel A, 1/0 selects channel B, and 0/0 selects both.
- R3: In split-strobe mode with both selects low and `wr_n` low, the addressed register of both channels takes `wdata` at the same clock edge.
- R4: With both channels selected, an active read drives `rdata`=0x00 and `rvalid`=0.
- R5: In single-strobe mode (`intel_mode`=0 at reset), `cs0_n` low enables the device, and `addr[3]`=0 selects channel A while `addr[3]`=1 selects channel B. `rw_n`=0 writes and `rw_n`=1 reads. With `cs0_n` high, no channel is selected for any value of `addr[3]`.
- R6: In split-strobe mode, `addr[3]` has no effect on which channel is selected.
- R7: Register offsets on `addr[2:0]` are as follows. Offset 0 is the divisor low byte when line control bit 7 is 1; otherwise it reads receive data as 0x00 and discards writes. Offset 1 is the divisor high byte when line control bit 7 is 1; otherwise it is interrupt enable. The other offsets are 2 status/FIFO control, 3 line control, 4 modem control, 5 line status, 6 modem status and 7 scratch.
- R8: When a channel's divisor low and high bytes are both 0x00, a read of offset 1 with line control bit 7 set returns 0x0A and a read of offset 0 returns revision code 0x01. Otherwise these reads return the stored bytes.
- R9: Outside an active read of exactly one channel, `rdata` is 0x00 and `rvalid` is 0.
- R10: The bus mode is taken from `intel_mode` only while `rst_n` is low. Changing `intel_mode` after reset has no effect.
- R11: The status registers read fixed values. Offset 2 reads 0x01, or 0xC1 once FIFO control bit 0 has been written as 1. Offset 5 reads 0x60 and offset 6 reads 0x00.
- R12: A write is stored at the rising clock edge where it is presented. A read is combinational, so it shows the old value before that edge and the new value after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; bus mode is sampled while low |
| intel_mode | input | 1 | Bus mode strap: 1 split-strobe, 0 single-strobe |
| cs0_n | input | 1 | Channel A select (split), device select (single) |
| cs1_n | input | 1 | Channel B select (split), unused (single) |
| addr | input | 4 | Register offset in [2:0]; channel bit [3] in single-strobe mode |
| rd_n | input | 1 | Active-low read strobe, split-strobe mode |
| wr_n | input | 1 | Active-low write strobe, split-strobe mode |
| rw_n | input | 1 | Read (1) / write (0) direction, single-strobe mode |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, 0x00 when not valid |
| rvalid | output | 1 | High during a read of exactly one channel |

## Verification
Read data and `rvalid` follow the bus inputs within the same cycle. A write becomes visible one rising edge after it is presented, and the bus mode is fixed by the level of the strap during the last clocked reset cycle. The bench drives inputs on the falling edge and samples outputs 1 ns later. It therefore checks reads in the cycle they are posed, sees a write's old value before the edge and its new value in the following cycle, and changes the strap only after reset is released.

// File: rtl/duart_host_decoder.sv
`timescale 1ns/1ps
module duart_host_decoder #(
  parameter logic [7:0] DEV_CODE     = 8'h0A,
  parameter logic [7:0] REV_CODE     = 8'h01,
  parameter logic [7:0] SCRATCH_INIT = 8'hFF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       intel_mode,
  input  logic       cs0_n,
  input  logic       cs1_n,
  input  logic [3:0] addr,
  input  logic       rd_n,
  input  logic       wr_n,
  input  logic       rw_n,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       rvalid
);
  localparam int NCH = 2;

  logic       mode_q;
  logic [7:0] lcr [NCH];
  logic [7:0] ier [NCH];
  logic [7:0] mcr [NCH];
  logic [7:0] spr [NCH];
  logic [7:0] dll [NCH];
  logic [7:0] dlm [NCH];
  logic       fen [NCH];
  logic [7:0] pick;

  always_ff @(posedge clk)
    if (!rst_n) mode_q <= intel_mode;

  wire [1:0] sel = mode_q ? {~cs1_n, ~cs0_n}
                          : {~cs0_n & addr[3], ~cs0_n & ~addr[3]};
  wire       rd  = mode_q ? ~rd_n : rw_n;
  wire       wr  = mode_q ? ~wr_n : ~rw_n;
  wire [2:0] off = addr[2:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        lcr[c] <= 8'h00; ier[c] <= 8'h00; mcr[c] <= 8'h00;
        spr[c] <= SCRATCH_INIT; dll[c] <= 8'h00; dlm[c] <= 8'h00;
        fen[c] <= 1'b0;
      end
    end else begin
      for (int c = 0; c < NCH; c++) begin
        if (wr && sel[c]) begin
          case (off)
            3'd0: if (lcr[c][7]) dll[c] <= wdata;
            3'd1: if (lcr[c][7]) dlm[c] <= wdata; else ier[c] <= wdata;
            3'd2: fen[c] <= wdata[0];
            3'd3: lcr[c] <= wdata;
            3'd4: mcr[c] <= wdata;
            3'd7: spr[c] <= wdata;
            default: ;
          endcase
        end
      end
    end
  end

  wire ch    = sel[1];
  wire dlab  = lcr[ch][7];
  wire id_on = (dll[ch] == 8'h00) && (dlm[ch] == 8'h00);

  always_comb begin
    case (off)
      3'd0:    pick = dlab ? (id_on ? REV_CODE : dll[ch]) : 8'h00;
      3'd1:    pick = dlab ? (id_on ? DEV_CODE : dlm[ch]) : ier[ch];
      3'd2:    pick = {fen[ch], fen[ch], 6'b000001};
      3'd3:    pick = lcr[ch];
      3'd4:    pick = mcr[ch];
      3'd5:    pick = 8'h60;
      3'd6:    pick = 8'h00;
      default: pick = spr[ch];
    endcase
  end

  assign rvalid = rd && (sel == 2'b01 || sel == 2'b10);
  assign rdata  = rvalid ? pick : 8'h00;

  p_dual_read_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && !cs0_n && !cs1_n) |-> (rdata == 8'h00 && !rvalid));

  p_no_strobe_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && rd_n) |-> (rdata == 8'h00 && !rvalid));

  p_broadcast_scratch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && !cs0_n && !cs1_n && !wr_n && addr[2:0] == 3'd7)
      |=> (spr[0] == $past(wdata) && spr[1] == $past(wdata)));

  p_single_deselect_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q && cs0_n) |=> $stable({lcr[0], lcr[1], ier[0], ier[1], mcr[0], mcr[1],
                                    spr[0], spr[1], dll[0], dll[1], dlm[0], dlm[1]}));

  p_id_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rvalid && addr[2:0] == 3'd1 && lcr[sel[1]][7] &&
     dll[sel[1]] == 8'h00 && dlm[sel[1]] == 8'h00) |-> (rdata == DEV_CODE));

  p_mode_locked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> $stable(mode_q));
endmodule

// File: tb/duart_host_decoder_test.sv
`timescale 1ns/1ps
module duart_host_decoder_test;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       intel_mode = 1;
  logic       cs0_n = 1, cs1_n = 1, rd_n = 1, wr_n = 1, rw_n = 1;
  logic [3:0] addr = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic       rvalid;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  duart_host_decoder uut (.clk(clk), .rst_n(rst_n), .intel_mode(intel_mode),
    .cs0_n(cs0_n), .cs1_n(cs1_n), .addr(addr), .rd_n(rd_n), .wr_n(wr_n),
    .rw_n(rw_n), .wdata(wdata), .rdata(rdata), .rvalid(rvalid));

  task automatic check(input string tag, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    cs0_n = 1; cs1_n = 1; rd_n = 1; wr_n = 1; rw_n = 1; addr = 0; wdata = 0;
  endtask

  task automatic do_reset(input logic mode);
    @(negedge clk); idle(); intel_mode = mode; rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic iw(input logic [1:0] csn, input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); cs0_n = csn[0]; cs1_n = csn[1]; addr = a; wdata = d; wr_n = 0;
    @(negedge clk); idle();
  endtask

  task automatic ir(input logic [1:0] csn, input logic [3:0] a, output logic [8:0] v);
    @(negedge clk); cs0_n = csn[0]; cs1_n = csn[1]; addr = a; rd_n = 0;
    #1 v = {rvalid, rdata};
    idle();
  endtask

  task automatic mw(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); cs0_n = 0; addr = a; wdata = d; rw_n = 0;
    @(negedge clk); idle();
  endtask

  task automatic mr(input logic [3:0] a, output logic [8:0] v);
    @(negedge clk); cs0_n = 0; addr = a; rw_n = 1;
    #1 v = {rvalid, rdata};
    idle();
  endtask

  localparam logic [1:0] SA = 2'b10, SB = 2'b01, SAB = 2'b00, SN = 2'b11;

  task automatic t_reset_defaults();
    logic [8:0] v;
    do_reset(1);
    ir(SA, 4'd3, v); check("R1 lcr A", v, 9'h100);
    ir(SB, 4'd1, v); check("R1 ier B", v, 9'h100);
    ir(SA, 4'd4, v); check("R1 mcr A", v, 9'h100);
    ir(SB, 4'd7, v); check("R1 spr B", v, 9'h1FF);
    ir(SA, 4'd5, v); check("R11 lsr", v, 9'h160);
    ir(SA, 4'd6, v); check("R11 msr", v, 9'h100);
    ir(SB, 4'd2, v); check("R11 isr", v, 9'h101);
    ir(SN, 4'd7, v); check("R9 no select", v, 9'h000);
    @(negedge clk); cs0_n = 0; addr = 4'd7; #1 check("R9 no strobe", {rvalid, rdata}, 9'h000);
    idle();
  endtask

  task automatic t_intel_select();
    logic [8:0] v;
    iw(SA, 4'd7, 8'h11);
    iw(SB, 4'd7, 8'h22);
    ir(SA, 4'd7, v); check("R2 chan A", v, 9'h111);
    ir(SB, 4'd7, v); check("R2 chan B", v, 9'h122);
    iw(SN, 4'd7, 8'h99);
    ir(SA, 4'd7, v); check("R2 none A", v, 9'h111);
    ir(SB, 4'd7, v); check("R2 none B", v, 9'h122);
    iw(SA, 4'hF, 8'h33);
    ir(SA, 4'hF, v); check("R6 a3 A", v, 9'h133);
    ir(SB, 4'h7, v); check("R6 a3 B", v, 9'h122);
    @(negedge clk); cs0_n = 0; addr = 4'd4; wdata = 8'h7E; wr_n = 0; rd_n = 0;
    #1 check("R12 before edge", {rvalid, rdata}, 9'h100);
    @(negedge clk); wr_n = 1;
    #1 check("R12 after edge", {rvalid, rdata}, 9'h17E);
    idle();
  endtask

  task automatic t_broadcast();
    logic [8:0] v;
    iw(SAB, 4'd7, 8'h5A);
    ir(SA, 4'd7, v); check("R3 bcast A", v, 9'h15A);
    ir(SB, 4'd7, v); check("R3 bcast B", v, 9'h15A);
    ir(SAB, 4'd7, v); check("R4 dual read", v, 9'h000);
  endtask

  task automatic t_dlab_id();
    logic [8:0] v;
    iw(SA, 4'd3, 8'h80);
    ir(SA, 4'd0, v); check("R8 rev", v, 9'h101);
    ir(SA, 4'd1, v); check("R8 dev", v, 9'h10A);
    iw(SA, 4'd0, 8'h05);
    ir(SA, 4'd0, v); check("R8 dll stored", v, 9'h105);
    ir(SA, 4'd1, v); check("R8 dlm stored", v, 9'h100);
    iw(SA, 4'd3, 8'h03);
    ir(SA, 4'd0, v); check("R7 rhr", v, 9'h100);
    iw(SA, 4'd1, 8'h0F);
    ir(SA, 4'd1, v); check("R7 ier", v, 9'h10F);
    iw(SA, 4'd0, 8'hAA);
    iw(SA, 4'd3, 8'h83);
    ir(SA, 4'd0, v); check("R7 thr ignored", v, 9'h105);
    iw(SA, 4'd0, 8'h00);
    ir(SA, 4'd1, v); check("R8 id again", v, 9'h10A);
    ir(SB, 4'd1, v); check("R7 B ier", v, 9'h100);
  endtask

  task automatic t_status();
    logic [8:0] v;
    iw(SA, 4'd2, 8'h01);
    ir(SA, 4'd2, v); check("R11 isr fifo", v, 9'h1C1);
    ir(SB, 4'd2, v); check("R11 isr B", v, 9'h101);
  endtask

  task automatic t_single_strobe();
    logic [8:0] v;
    do_reset(0);
    mr(4'h7, v); check("R1 spr after reset", v, 9'h1FF);
    intel_mode = 1;
    mw(4'h7, 8'h44);
    mw(4'hF, 8'h55);
    mr(4'h7, v); check("R5 chan A", v, 9'h144);
    mr(4'hF, v); check("R10 mode held", v, 9'h155);
    @(negedge clk); cs0_n = 1; addr = 4'hF; wdata = 8'h66; rw_n = 0;
    @(negedge clk); cs0_n = 1; addr = 4'h7; rw_n = 0;
    @(negedge clk); idle();
    mr(4'hF, v); check("R5 deselect B", v, 9'h155);
    mr(4'h7, v); check("R5 deselect A", v, 9'h144);
    @(negedge clk); cs0_n = 1; addr = 4'h7; rw_n = 1;
    #1 check("R5 deselect read", {rvalid, rdata}, 9'h000);
    idle();
  endtask

  initial begin
    t_reset_defaults();
    t_intel_select();
    t_broadcast();
    t_dlab_id();
    t_status();
    t_single_strobe();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule